// File: doc/BRIEF.md
# Masked Vector Shift Unit

This block shifts every element of a 16-lane vector of 32-bit integers in a single registered stage. Three shift kinds are supported: logical left, logical right, and arithmetic right. The shift count comes from one of two places. An 8-bit immediate can apply one count to all lanes. A count vector can supply one 32-bit count per lane.

Counts of 32 or more are handled as follows. Logical shifts saturate to zero. Arithmetic right shifts saturate to a copy of the sign bit in every bit position.

Each shifted lane is merged into the previous destination vector under a 16-bit write mask. A lane whose mask bit is clear keeps its old destination value. The caller also supplies the index of the mask register it used. Index zero stands for an implied all-ones mask, so every lane is written and the mask bits are ignored.

The result and a valid strobe appear one clock after the inputs are presented.

Top module: `vshift_merge`

## Requirements
- R1: `out_valid` is low after reset and, in every cycle after reset, equals `in_valid` of the previous cycle. `out_vec` is all zeros after reset.
- R2: With `op_kind` = 2'b00 (logical left) and a count below 32, a lane's result is its source shifted left with zeros entering at the low end.
- R3: With `op_kind` = 2'b01 (logical right) and a count below 32, a lane's result is its source shifted right with zeros entering at the high end.
- R4: With `op_kind` = 2'b10 (arithmetic right) and a count below 32, a lane's result is its source shifted right with copies of source bit 31 entering at the high end.
- R5: For `op_kind` 2'b00 or 2'b01, a lane whose count is 32 or more yields zero.
- R6: For `op_kind` 2'b10, a lane whose count is 32 or more yields 32 copies of its source bit 31.
- R7: When `use_imm` = 1, every lane uses `imm_cnt`, read as an unsigned 8-bit value, as its count, so values 32 to 255 saturate.
- R8: When `use_imm` = 0, lane i uses bits [32i+31:32i] of `cnt_vec`, read as an unsigned 32-bit value. Any set bit above bit 4 saturates the lane, even when the low five bits are zero.
- R9: When `mask_idx` is nonzero and `mask_bits[i]` is 0, lane i of the result equals lane i of `old_dst`.
- R10: When `mask_idx` = 0, all lanes are written with the shift result regardless of `mask_bits`.
- R11: `op_kind` = 2'b11 is a reserved encoding: every lane of the result equals `old_dst`.
- R12: In a cycle after one with `in_valid` low, `out_vec` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs hold an operation this cycle |
| op_kind | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 reserved |
| use_imm | input | 1 | 1: immediate count, 0: per-lane count vector |
| imm_cnt | input | 8 | Shared unsigned shift count |
| src_vec | input | 512 | Source elements, lane i at bits [32i+31:32i] |
| cnt_vec | input | 512 | Per-lane unsigned counts |
| old_dst | input | 512 | Prior destination contents |
| mask_idx | input | 3 | Index of the mask register used; 0 means implied all ones |
| mask_bits | input | 16 | Write mask, bit i for lane i |
| out_valid | output | 1 | Result valid |
| out_vec | output | 512 | Merged result |

## Verification
The hardest case to reach is a per-lane count that is 32 or more while its low five bits are zero. A shifter that looks only at the low bits would treat such a count as zero and return the source unchanged. Random counts almost never land on that pattern.

The stimulus therefore places counts such as 0x20, 0x100 and 0x8000_0000 in chosen lanes. Random traffic draws about a quarter of its counts from the full 32-bit range. The mask-index-zero case is reached with `mask_bits` held at zero, so that any leak of the raw mask shows up as untouched lanes.

// File: rtl/vshift_merge.sv
module vshift_merge #(
  parameter int LANES = 16,
  parameter int EW    = 32,
  parameter int IMMW  = 8,
  parameter int MIDXW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          op_kind,
  input  logic                use_imm,
  input  logic [IMMW-1:0]     imm_cnt,
  input  logic [LANES*EW-1:0] src_vec,
  input  logic [LANES*EW-1:0] cnt_vec,
  input  logic [LANES*EW-1:0] old_dst,
  input  logic [MIDXW-1:0]    mask_idx,
  input  logic [LANES-1:0]    mask_bits,
  output logic                out_valid,
  output logic [LANES*EW-1:0] out_vec
);
  localparam int VW  = LANES * EW;
  localparam int SHW = $clog2(EW);
  localparam logic [1:0] OP_SLL = 2'b00;
  localparam logic [1:0] OP_SRL = 2'b01;
  localparam logic [1:0] OP_SRA = 2'b10;

  logic [VW-1:0] merged;
  logic          all_on;

  assign all_on = (mask_idx == '0);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [EW-1:0]  s, c, o, res;
    logic [SHW-1:0] amt;
    logic           big, en;

    assign s   = src_vec[i*EW +: EW];
    assign c   = cnt_vec[i*EW +: EW];
    assign o   = old_dst[i*EW +: EW];
    assign amt = use_imm ? imm_cnt[SHW-1:0] : c[SHW-1:0];
    assign big = use_imm ? |imm_cnt[IMMW-1:SHW] : |c[EW-1:SHW];
    assign en  = all_on | mask_bits[i];

    always_comb begin
      res = o;
      if (en) begin
        case (op_kind)
          OP_SLL:  res = big ? '0 : (s << amt);
          OP_SRL:  res = big ? '0 : (s >> amt);
          OP_SRA:  res = big ? {EW{s[EW-1]}} : $unsigned($signed(s) >>> amt);
          default: res = o;
        endcase
      end
    end

    assign merged[i*EW +: EW] = res;

    p_masked_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mask_idx != '0 && !mask_bits[i])
        |=> out_vec[i*EW +: EW] == $past(old_dst[i*EW +: EW]));

    p_logic_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (all_on || mask_bits[i]) && (op_kind == OP_SLL || op_kind == OP_SRL) &&
       (use_imm ? (imm_cnt >= IMMW'(EW)) : (c >= EW'(EW))))
        |=> out_vec[i*EW +: EW] == '0);

    p_sign_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (all_on || mask_bits[i]) && op_kind == OP_SRA &&
       (use_imm ? (imm_cnt >= IMMW'(EW)) : (c >= EW'(EW))))
        |=> out_vec[i*EW +: EW] == {EW{$past(src_vec[i*EW + EW - 1])}});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_vec <= merged;
    end
  end

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_vec));

  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_kind == 2'b11) |=> out_vec == $past(old_dst));

endmodule

// File: tb/vshift_merge_tb_top.sv
`timescale 1ns/1ps
module vshift_merge_tb_top;
  localparam int L = 16;
  localparam int W = 32;
  localparam int VW = L * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] op_kind = '0;
  logic use_imm = 1'b0;
  logic [7:0] imm_cnt = '0;
  logic [VW-1:0] src_vec = '0, cnt_vec = '0, old_dst = '0;
  logic [2:0] mask_idx = '0;
  logic [L-1:0] mask_bits = '0;
  logic out_valid;
  logic [VW-1:0] out_vec;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vshift_merge dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_kind(op_kind),
    .use_imm(use_imm), .imm_cnt(imm_cnt), .src_vec(src_vec), .cnt_vec(cnt_vec),
    .old_dst(old_dst), .mask_idx(mask_idx), .mask_bits(mask_bits),
    .out_valid(out_valid), .out_vec(out_vec)
  );

  function automatic logic [W-1:0] ref_lane(logic [1:0] op, logic ui, logic [7:0] imm,
                                            logic [W-1:0] s, logic [W-1:0] c,
                                            logic [W-1:0] o, logic en);
    logic [W-1:0] n;
    n = ui ? {24'b0, imm} : c;
    if (!en || op == 2'b11) return o;
    case (op)
      2'b00:   return (n >= 32) ? '0 : (s << n);
      2'b01:   return (n >= 32) ? '0 : (s >> n);
      default: return (n >= 32) ? {W{s[W-1]}} : $unsigned($signed(s) >>> n);
    endcase
  endfunction

  task automatic check_vec(string tag, logic [VW-1:0] got, logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic check_bit(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic run_op(string tag, logic [1:0] op, logic ui, logic [7:0] imm,
                        logic [VW-1:0] s, logic [VW-1:0] c, logic [VW-1:0] o,
                        logic [2:0] idx, logic [L-1:0] mb);
    logic [VW-1:0] exp;
    for (int i = 0; i < L; i++)
      exp[i*W +: W] = ref_lane(op, ui, imm, s[i*W +: W], c[i*W +: W], o[i*W +: W],
                               (idx == 0) || mb[i]);
    @(negedge clk);
    in_valid = 1'b1; op_kind = op; use_imm = ui; imm_cnt = imm;
    src_vec = s; cnt_vec = c; old_dst = o; mask_idx = idx; mask_bits = mb;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({tag, " R1 valid"}, out_valid, 1'b1);
    check_vec(tag, out_vec, exp);
  endtask

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < L; i++) v[i*W +: W] = $urandom;
    return v;
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] s, c, o, keep;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check_bit("R1 reset valid", out_valid, 1'b0);
    check_vec("R1 reset data", out_vec, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1 idle valid", out_valid, 1'b0);

    s = rnd_vec(); o = rnd_vec();
    for (int i = 0; i < L; i++) s[i*W + W - 1] = i[0];
    run_op("R2 sll imm 5", 2'b00, 1'b1, 8'd5, s, '0, o, 3'd0, '0);
    run_op("R3 srl imm 31", 2'b01, 1'b1, 8'd31, s, '0, o, 3'd0, '0);
    run_op("R4 sra imm 7", 2'b10, 1'b1, 8'd7, s, '0, o, 3'd0, '0);
    run_op("R4 sra imm 0", 2'b10, 1'b1, 8'd0, s, '0, o, 3'd0, '0);
    run_op("R5 R7 sll imm 32", 2'b00, 1'b1, 8'd32, s, '0, o, 3'd0, '0);
    run_op("R5 R7 srl imm 255", 2'b01, 1'b1, 8'd255, s, '0, o, 3'd0, '0);
    run_op("R6 R7 sra imm 200", 2'b10, 1'b1, 8'd200, s, '0, o, 3'd0, '0);

    for (int i = 0; i < L; i++) c[i*W +: W] = i;
    c[3*W +: W] = 32'h20; c[5*W +: W] = 32'h100; c[9*W +: W] = 32'h8000_0000;
    c[12*W +: W] = 32'h0001_0003;
    run_op("R8 R5 var sll", 2'b00, 1'b0, 8'd3, s, c, o, 3'd0, '0);
    run_op("R8 R5 var srl", 2'b01, 1'b0, 8'd3, s, c, o, 3'd0, '0);
    run_op("R8 R6 var sra", 2'b10, 1'b0, 8'd3, s, c, o, 3'd0, '0);

    run_op("R9 partial mask", 2'b01, 1'b1, 8'd4, s, c, o, 3'd2, 16'hA5C3);
    run_op("R9 empty mask", 2'b10, 1'b0, 8'd0, s, c, o, 3'd7, 16'h0000);
    run_op("R10 idx0 ignores bits", 2'b00, 1'b0, 8'd0, s, c, o, 3'd0, 16'h0000);
    run_op("R11 reserved op", 2'b11, 1'b1, 8'd1, s, c, o, 3'd0, 16'hFFFF);

    keep = out_vec;
    @(negedge clk);
    src_vec = rnd_vec(); old_dst = rnd_vec(); op_kind = 2'b00;
    @(negedge clk);
    check_bit("R1 no valid", out_valid, 1'b0);
    check_vec("R12 hold", out_vec, keep);

    for (int t = 0; t < 400; t++) begin
      s = rnd_vec(); o = rnd_vec();
      for (int i = 0; i < L; i++)
        c[i*W +: W] = ($urandom % 4 == 0) ? $urandom : ($urandom % 32);
      run_op("R2 R3 R4 R7 R8 R9 R10 random", 2'($urandom), 1'($urandom),
             8'(($urandom % 2) ? $urandom % 40 : $urandom), s, c, o,
             3'($urandom), 16'($urandom));
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule